// File: doc/BRIEF.md
# Event-Resettable 16-bit Timer

This block is a 16-bit up-counter that sits behind an 8-bit register port. It counts in one of three ways: every system clock cycle, rising edges of an external input taken through a two-stage synchronizer, or rising edges of that input sampled raw with no synchronizer. The counted events pass through a prescaler that divides by 1, 2, 4 or 8. When the count wraps from FFFFh to 0000h, the block sets a sticky overflow flag. An enable bit gates that flag onto a registered interrupt line.

A single-cycle trigger input clears the count to zero. When the trigger comes from a compare match elsewhere in the chip, the compared value acts as the timer period. A software write to the counter in the same cycle overrides the trigger. A mode bit selects how the two counter bytes are accessed. In direct mode each byte is read and written on its own. In buffered mode a read of the low byte latches the high byte for a later read, and a write of the low byte loads the whole 16-bit value in one step.

The port has four addresses: 0 is control, 1 is the count low byte, 2 is the count high byte, and 3 is interrupt status and enable. Read data is registered. It appears one cycle after the read strobe and shows the state from before that clock edge.

Top module: `evt_timer16`

## Requirements
- R1: After reset, all four addresses read 00h and the interrupt output is low.
- R2: The control byte has these fields: bit 7 buffered mode, bit 6 status (reads 0 and ignores writes), bits 5:4 prescale, bit 3 oscillator enable (stored only), bit 2 synchronizer bypass, bit 1 source (1 = external), bit 0 run enable.
- R3: With source 0 and run enable 1, the count advances on every clock, scaled by the prescale. With run enable 0 it holds.
- R4: Prescale codes 00, 01, 10 and 11 give one count per 1, 2, 4 and 8 events. A control write clears the prescaler, and the counter does not advance in that cycle.
- R5: With source 1 and bypass 0, each rising edge of the external input is counted once. The increment lands at the second clock edge after the edge where the input is first sampled high.
- R6: With source 1 and bypass 1, a rising edge is counted at the clock edge where the input is first sampled high.
- R7: A wrap from FFFFh to 0000h sets the flag at address 3 bit 0. The flag stays set until address 3 is written with bit 0 = 0. If an overflow and a clear happen in the same cycle, the overflow wins.
- R8: The interrupt output equals the flag AND address 3 bit 1, registered.
- R9: A trigger pulse clears the count to 0000h when the source is internal or the synchronizer is in use. In unsynchronized external mode the trigger is ignored.
- R10: A counter-byte write in the same cycle as a trigger takes effect, and the trigger is dropped.
- R11: In buffered mode, a read of the low byte latches the high byte into a buffer, and a read of address 2 returns that buffer. A write to address 2 fills the buffer only. A write to the low byte loads {buffer, data} into the counter.
- R12: In direct mode, addresses 1 and 2 read and write the live low and high bytes. A write changes only its own byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after bus_rd |
| ext_clk_in | input | 1 | External count input |
| evt_trig | input | 1 | Special-event reset pulse |
| irq | output | 1 | Overflow interrupt, registered |

## Verification
The counter is driven in three ways: from the internal clock at all four prescale codes, from slow pulses on the external input with the synchronizer, and from single-cycle pulses with the synchronizer bypassed. Comparing these shows whether edges are counted exactly once and whether the synchronizer delay is correct. The trigger is pulsed in each source mode, so a correct clear can be told apart from the case where the trigger should be ignored. It is also pulsed together with a byte write to show that the write takes priority. A start value just below FFFFh in buffered mode exercises the atomic load, the wrap, the sticky flag and its mask. Reading the low byte and then the high byte while the counter is running shows whether the latched high byte is returned or the live one.

// File: rtl/evt_timer16_pkg.sv
package evt_timer16_pkg;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CLO  = 2'd1;
  localparam logic [1:0] A_CHI  = 2'd2;
  localparam logic [1:0] A_IRQ  = 2'd3;

  // bit order is the register layout: [7] buffered .. [0] run enable
  typedef struct packed {
    logic       wide;
    logic       stat;
    logic [1:0] ps;
    logic       osc;
    logic       nosync;
    logic       src;
    logic       en;
  } ctrl_t;

  localparam logic [7:0] CTRL_WMASK = 8'hBF;
endpackage

// File: rtl/evt_timer16_edge.sv
module evt_timer16_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_in,
  input  logic src_ext,
  input  logic no_sync,
  output logic ev
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q;
  logic         sync_prev_q;
  logic         raw_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= ext_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[MSB-1:0], ext_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_prev_q <= 1'b0;
      raw_q       <= 1'b0;
    end else begin
      sync_prev_q <= sync_q[MSB];
      raw_q       <= ext_in;
    end
  end

  always_comb begin
    if (!src_ext)     ev = 1'b1;
    else if (no_sync) ev = ext_in & ~raw_q;
    else              ev = sync_q[MSB] & ~sync_prev_q;
  end
endmodule

// File: rtl/evt_timer16_presc.sv
module evt_timer16_presc #(
  parameter int PS_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            ev,
  input  logic            en,
  input  logic [PS_W-1:0] ps,
  output logic            tick
);
  localparam int CW = (1 << PS_W) - 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  always_comb begin
    last = CW'((32'd1 << ps) - 32'd1);
    tick = en & ev & ~clr & (cnt_q == last);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (en && ev) begin
      if (cnt_q == last) cnt_q <= '0;
      else               cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/evt_timer16_core.sv
module evt_timer16_core #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          zero,
  input  logic          inc,
  output logic [CW-1:0] cnt_q,
  output logic          wrap
);
  always_comb wrap = inc & ~load & ~zero & (&cnt_q);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (zero) cnt_q <= '0;
    else if (inc)  cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/evt_timer16.sv
module evt_timer16
  import evt_timer16_pkg::*;
#(
  parameter int DW          = 8,
  parameter int PS_W        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          ext_clk_in,
  input  logic          evt_trig,
  output logic          irq
);
  localparam int CW = 2 * DW;

  ctrl_t         ctrl_q;
  logic [DW-1:0] hbuf_q;
  logic          flag_q, ie_q, flag_d, ie_d;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] ld_val;
  logic          wrap, ev, tick, ld, trig_ok;
  logic          wr_ctrl, wr_lo, wr_hi, wr_irq, rd_lo;
  logic          wide_md, src_ext, no_sync;

  assign wide_md = ctrl_q.wide;
  assign src_ext = ctrl_q.src;
  assign no_sync = ctrl_q.nosync;

  always_comb begin
    wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    wr_lo   = bus_wr && (bus_addr == A_CLO);
    wr_hi   = bus_wr && (bus_addr == A_CHI);
    wr_irq  = bus_wr && (bus_addr == A_IRQ);
    rd_lo   = bus_rd && (bus_addr == A_CLO);
    ld      = wr_lo | (wr_hi & ~wide_md);
    if (wide_md)    ld_val = {hbuf_q, bus_wdata};
    else if (wr_lo) ld_val = {cnt_q[CW-1:DW], bus_wdata};
    else            ld_val = {bus_wdata, cnt_q[DW-1:0]};
    trig_ok = evt_trig & (~src_ext | ~no_sync);
  end

  evt_timer16_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .ext_in(ext_clk_in),
    .src_ext(src_ext), .no_sync(no_sync), .ev(ev)
  );

  evt_timer16_presc #(.PS_W(PS_W)) u_presc (
    .clk(clk), .rst(rst), .clr(wr_ctrl), .ev(ev),
    .en(ctrl_q.en), .ps(ctrl_q.ps[PS_W-1:0]), .tick(tick)
  );

  evt_timer16_core #(.CW(CW)) u_core (
    .clk(clk), .rst(rst), .load(ld), .load_val(ld_val),
    .zero(trig_ok), .inc(tick), .cnt_q(cnt_q), .wrap(wrap)
  );

  always_comb begin
    flag_d = flag_q;
    ie_d   = ie_q;
    if (wrap)                         flag_d = 1'b1;
    else if (wr_irq && !bus_wdata[0]) flag_d = 1'b0;
    if (wr_irq)                       ie_d   = bus_wdata[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      hbuf_q    <= '0;
      flag_q    <= 1'b0;
      ie_q      <= 1'b0;
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[7:0] & CTRL_WMASK);
      if (wide_md && wr_hi)      hbuf_q <= bus_wdata;
      else if (wide_md && rd_lo) hbuf_q <= cnt_q[CW-1:DW];
      flag_q <= flag_d;
      ie_q   <= ie_d;
      irq    <= flag_d & ie_d;
      if (bus_rd) begin
        case (bus_addr)
          A_CTRL:  bus_rdata <= DW'(ctrl_q);
          A_CLO:   bus_rdata <= cnt_q[DW-1:0];
          A_CHI:   bus_rdata <= wide_md ? hbuf_q : cnt_q[CW-1:DW];
          default: bus_rdata <= DW'({ie_q, flag_q});
        endcase
      end
    end
  end
endmodule

// File: rtl/evt_timer16_chk.sv
module evt_timer16_chk (
  input logic        clk,
  input logic        rst,
  input logic        bus_wr,
  input logic [1:0]  bus_addr,
  input logic [7:0]  bus_wdata,
  input logic        evt_trig,
  input logic [15:0] cnt,
  input logic        flag,
  input logic        src_ext,
  input logic        no_sync
);
  // R3: without writes or trigger the count moves by at most one
  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!(bus_wr && bus_addr != 2'd3) && !evt_trig)
    |=> (cnt == $past(cnt) || cnt == $past(cnt) + 16'd1));

  // R4: a control write freezes the count for that cycle
  p_ctrl_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd0 && !evt_trig) |=> $stable(cnt));

  // R7: the overflow flag is sticky until cleared through address 3
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (flag && !(bus_wr && bus_addr == 2'd3)) |=> flag);

  // R9: trigger clears the count when resets are honoured
  p_trig_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (evt_trig && !(bus_wr && (bus_addr == 2'd1 || bus_addr == 2'd2))
     && (!src_ext || !no_sync)) |=> (cnt == 16'd0));

  // R10: a low-byte write beats a simultaneous trigger
  p_write_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd1 && evt_trig) |=> (cnt[7:0] == $past(bus_wdata)));
endmodule

bind evt_timer16 evt_timer16_chk u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .evt_trig(evt_trig), .cnt(cnt_q),
  .flag(flag_q), .src_ext(src_ext), .no_sync(no_sync)
);

// File: tb/evt_timer16_tb.sv
module evt_timer16_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       ext_clk_in = 1'b0, evt_trig = 1'b0;
  logic       irq;

  int    checks = 0, errors = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #10 clk = ~clk;

  evt_timer16 u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_clk_in(ext_clk_in), .evt_trig(evt_trig), .irq(irq)
  );

  // behavioural reference model
  logic [7:0]  m_ctrl, m_hbuf, m_rdata;
  logic [15:0] m_cnt;
  logic        m_flag, m_ie, m_irq, m_s1, m_s2, m_prev, m_raw;
  int          m_pcnt, ratio;
  logic        ev, pulse, ovf, src, nos, wide;

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = 0; m_hbuf = 0; m_rdata = 0; m_cnt = 0; m_flag = 0; m_ie = 0;
      m_irq = 0; m_s1 = 0; m_s2 = 0; m_prev = 0; m_raw = 0; m_pcnt = 0;
    end else begin
      src = m_ctrl[1]; nos = m_ctrl[2]; wide = m_ctrl[7];
      ratio = 1 << m_ctrl[5:4];
      ev = !src ? 1'b1 : (nos ? (ext_clk_in && !m_raw) : (m_s2 && !m_prev));
      m_prev = m_s2; m_s2 = m_s1; m_s1 = ext_clk_in; m_raw = ext_clk_in;
      pulse = 1'b0; ovf = 1'b0;
      if (bus_wr && bus_addr == 2'd0) m_pcnt = 0;
      else if (m_ctrl[0] && ev) begin
        if (m_pcnt + 1 >= ratio) begin pulse = 1'b1; m_pcnt = 0; end
        else m_pcnt = m_pcnt + 1;
      end
      if (bus_rd) begin
        case (bus_addr)
          2'd0: m_rdata = m_ctrl;
          2'd1: begin m_rdata = m_cnt[7:0]; if (wide) m_hbuf = m_cnt[15:8]; end
          2'd2: m_rdata = wide ? m_hbuf : m_cnt[15:8];
          default: m_rdata = {6'd0, m_ie, m_flag};
        endcase
      end
      if (bus_wr && bus_addr == 2'd1) m_cnt = wide ? {m_hbuf, bus_wdata} : {m_cnt[15:8], bus_wdata};
      else if (bus_wr && bus_addr == 2'd2 && !wide) m_cnt[15:8] = bus_wdata;
      else if (evt_trig && (!src || !nos)) m_cnt = 16'd0;
      else if (pulse) begin
        if (m_cnt == 16'hFFFF) ovf = 1'b1;
        m_cnt = m_cnt + 16'd1;
      end
      if (bus_wr && bus_addr == 2'd2 && wide) m_hbuf = bus_wdata;
      if (ovf) m_flag = 1'b1;
      else if (bus_wr && bus_addr == 2'd3 && !bus_wdata[0]) m_flag = 1'b0;
      if (bus_wr && bus_addr == 2'd3) m_ie = bus_wdata[1];
      if (bus_wr && bus_addr == 2'd0) m_ctrl = bus_wdata & 8'hBF;
      m_irq = m_flag & m_ie;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (bus_rdata !== m_rdata) begin
        errors++;
        $display("FAIL %s rdata actual %h expected %h", cur_req, bus_rdata, m_rdata);
      end
      checks++;
      if (irq !== m_irq) begin
        errors++;
        $display("FAIL %s irq actual %b expected %b", cur_req, irq, m_irq);
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic op(input bit w, input bit r, input logic [1:0] a, input logic [7:0] d);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d); op(1'b1, 1'b0, a, d); endtask
  task automatic rd(input logic [1:0] a); op(1'b0, 1'b1, a, 8'd0); endtask
  task automatic idle(input int n); repeat (n) @(negedge clk); endtask

  task automatic trig_pulse();
    evt_trig = 1'b1; @(negedge clk); evt_trig = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cur_req = "R1";
    for (int a = 0; a < 4; a++) begin rd(2'(a)); chk("R1", bus_rdata, 8'h00); end
    chk("R1", {7'd0, irq}, 8'h00);

    cur_req = "R2";
    wr(2'd0, 8'h48); rd(2'd0); chk("R2", bus_rdata, 8'h08);

    cur_req = "R3";
    wr(2'd1, 8'h00); wr(2'd0, 8'h01); idle(20); rd(2'd1);
    chk("R3", bus_rdata, 8'd20);
    wr(2'd0, 8'h00); idle(5); rd(2'd1); chk("R3", bus_rdata, 8'd21);

    cur_req = "R4";
    for (int p = 0; p < 4; p++) begin
      wr(2'd0, 8'h01 | 8'(p << 4)); wr(2'd1, 8'h00); idle(40); rd(2'd1);
    end

    cur_req = "R7";
    wr(2'd0, 8'h81); wr(2'd2, 8'hFF); wr(2'd1, 8'hF0); wr(2'd3, 8'h02);
    idle(20); rd(2'd3);
    cur_req = "R8"; chk("R8", {7'd0, irq}, 8'h01);
    wr(2'd3, 8'h02); chk("R7", {7'd0, irq}, 8'h00);
    rd(2'd3); chk("R7", bus_rdata, 8'h02);

    cur_req = "R11";
    rd(2'd1); idle(3); rd(2'd2);
    wr(2'd2, 8'h12); rd(2'd2); chk("R11", bus_rdata, 8'h12);
    wr(2'd1, 8'h00); wr(2'd0, 8'h80); rd(2'd2); chk("R11", bus_rdata, 8'h12);

    cur_req = "R12";
    wr(2'd0, 8'h01); wr(2'd2, 8'h34); rd(2'd2); chk("R12", bus_rdata, 8'h34);
    rd(2'd1);

    cur_req = "R5";
    wr(2'd0, 8'h03); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    for (int i = 0; i < 10; i++) begin
      ext_clk_in = 1'b1; idle(3); ext_clk_in = 1'b0; idle(3);
    end
    rd(2'd1); chk("R5", bus_rdata, 8'd10);

    cur_req = "R6";
    wr(2'd0, 8'h07); wr(2'd1, 8'h00);
    for (int i = 0; i < 8; i++) begin
      ext_clk_in = 1'b1; idle(1); ext_clk_in = 1'b0; idle(1);
    end
    rd(2'd1); chk("R6", bus_rdata, 8'd8);

    cur_req = "R9";
    wr(2'd0, 8'h01); idle(10); trig_pulse(); rd(2'd1); chk("R9", bus_rdata, 8'h00);
    wr(2'd0, 8'h03);
    for (int i = 0; i < 3; i++) begin ext_clk_in = 1'b1; idle(3); ext_clk_in = 1'b0; idle(3); end
    trig_pulse(); rd(2'd1); chk("R9", bus_rdata, 8'h00);
    wr(2'd0, 8'h07); wr(2'd1, 8'h05); trig_pulse(); rd(2'd1); chk("R9", bus_rdata, 8'h05);

    cur_req = "R10";
    wr(2'd0, 8'h01);
    evt_trig = 1'b1; wr(2'd1, 8'h55); evt_trig = 1'b0;
    rd(2'd1); chk("R10", bus_rdata, 8'h55);
    idle(4);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule